// File: doc/BRIEF.md
# Link Initialization Handshake Controller

This block sits between a host register bus and the bring-up logic for two line-side retimers, each carrying four serial links. After reset it exposes an init/control register, a firmware version word and one mode status word per retimer. The host reads the version word first. If the major number is 3 or higher, the host writes a start request that carries a 2-bit FEC choice for every link. The controller then configures the retimers one after another, taking a fixed number of cycles for each. When both are finished it sets a done flag and publishes the status words. If the major number is below 3, the configuration sequence starts by itself out of reset, and the start and FEC fields do not exist.

A retimer's status word carries a group code and a mode ID. A group code of zero means the retimer came up correctly. Any other value means configuration failed. The done flag is raised in both cases, so the host is never left waiting on a failed bring-up. The FEC choices are applied only on retimers whose mode uses 25G lanes, and the result is driven per link on `fec_o`. A per-retimer failure input lets a test force the error path.

Top module: `link_init_ctrl`

## Requirements
- R1: A bus request is acknowledged on `reg_ack_o` one cycle later. For a read, `reg_rdata_o` carries the addressed word in that same cycle. It is zero after a write, and zero for any address other than 0x1000, 0x1004, 0x1020 and 0x1024.
- R2: A read of address 0x1004 returns the version word: major in [31:28], minor in [27:24], patch in [23:20], and zero elsewhere.
- R3: A read of address 0x1000 returns the init register: done in bit 0, start in bit 1, and the eight latched 2-bit FEC fields in [23:8], with all other bits zero. The fields are ordered retimer A link 0 at [9:8] up to link 3 at [15:14], then retimer B link 0 at [17:16] up to link 3 at [23:22]. FEC codes are 0 = none, 1 = KR, 2 = Reed-Solomon, and 3 = reserved.
- R4: When major ≥ 3, a write to 0x1000 with bit 1 set, made while neither start nor done is set, does three things. It sets start, latches the FEC fields from [23:8], and raises `busy_o` on the next cycle. `done_o` is raised N_RT×STEP_CYCLES clock edges after the write edge.
- R5: The following writes to 0x1000 change nothing: a write while start or done is already set, and a write with bit 1 clear. The FEC fields, start, busy and done all keep their values, and no new sequence begins.
- R6: Before done is set, both status words (A at 0x1020, B at 0x1024) read as zero, which means group OK with the reset mode ID.
- R7: When done is set, each retimer's status word depends on its failure input, sampled during that retimer's step. With the input low, the word holds group 0 in [15:8] and the `rt_mode_i` mode ID in [7:0]. With the input high, it holds group FAIL_CODE (non-zero) and mode ID 0. Done rises whether or not a retimer failed. Mode IDs are 0 = reset, 1 = 4x10G, 2 = 4x25G, 3 = 2x25G, 4 = 2x25G+2x10G and 5 = 1x25G.
- R8: `fec_o` uses the same link packing as the init fields, with link 0 of retimer A in [1:0]. A link's field is set to its latched code only when three conditions all hold: done is set, the retimer's group code is 0, and its mode ID is neither 0 nor 1. In every other case the field is 0, and a latched code of 3 also gives 0.
- R9: When major < 3, the sequence starts by itself out of reset, and `done_o` rises N_RT×STEP_CYCLES edges after reset is released. Start and FEC fields read as zero, writes to 0x1000 have no effect, and `fec_o` stays zero.
- R10: `busy_o` and `done_o` are never both high, and once done is set it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Bus request strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 13 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| rt_mode_i | input | N_RT*8 | Mode ID each retimer reaches on success (retimer A in [7:0]) |
| rt_fail_i | input | N_RT | Forces configuration failure of a retimer |
| reg_ack_o | output | 1 | Request acknowledge, one cycle after the request |
| reg_rdata_o | output | 32 | Read data, valid with the acknowledge |
| busy_o | output | 1 | Configuration sequence running |
| done_o | output | 1 | Initialization finished |
| fec_o | output | N_RT*LINKS*2 | FEC code applied per link |

## Verification
Read data and the acknowledge are due one clock after the request edge. `busy_o` is due one clock after an accepted start write. `done_o`, the status words and `fec_o` are due exactly N_RT×STEP_CYCLES edges after that write; in the legacy variant they are due that many edges after reset is released. The bench model advances on the same rising edges as the design and counts those intervals explicitly. Every output is compared against the model on the following falling edge, so each result is checked in the exact cycle it becomes due, and never one cycle early or late. The legacy done edge is checked on every cycle from reset release until it becomes due.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned STS_W    = 16;
  localparam int unsigned FEC_BITS = 2;

  localparam logic [ADDR_W-1:0] ADDR_INIT  = 13'h1000;
  localparam logic [ADDR_W-1:0] ADDR_VER   = 13'h1004;
  localparam logic [ADDR_W-1:0] ADDR_STS_A = 13'h1020;

  localparam int unsigned INIT_DONE_BIT  = 0;
  localparam int unsigned INIT_START_BIT = 1;
  localparam int unsigned INIT_FEC_LSB   = 8;

  typedef enum logic [1:0] {
    FEC_NONE = 2'd0,
    FEC_KR   = 2'd1,
    FEC_RS   = 2'd2,
    FEC_RSVD = 2'd3
  } fec_e;

  localparam logic [7:0] MODE_RESET = 8'd0;
  localparam logic [7:0] MODE_4X10G = 8'd1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_e;

  typedef struct packed {
    logic [7:0] group;
    logic [7:0] mode_id;
  } sts_t;
endpackage

// File: rtl/lic_sequencer.sv
module lic_sequencer
  import lic_pkg::*;
#(
  parameter int unsigned N_RT        = 2,
  parameter int unsigned STEP_CYCLES = 32,
  parameter bit          AUTO_START  = 1'b0,
  parameter logic [7:0]  FAIL_CODE   = 8'h01
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [N_RT*8-1:0]     rt_mode_i,
  input  logic [N_RT-1:0]       rt_fail_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [N_RT*STS_W-1:0] sts_o
);
  localparam int unsigned CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int unsigned IDX_W = (N_RT > 1) ? $clog2(N_RT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_RT - 1);
  localparam seq_e RST_STATE = AUTO_START ? SEQ_RUN : SEQ_IDLE;

  seq_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             step_end;
  sts_t             res_q [N_RT];

  assign step_end = (state_q == SEQ_RUN) && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RST_STATE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_RUN;
          cnt_q   <= '0;
          idx_q   <= '0;
        end
        SEQ_RUN: begin
          if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            if (idx_q == IDX_LAST) state_q <= SEQ_DONE;
            else                   idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_DONE;
      endcase
    end
  end

  // one result slot per retimer, captured at the end of its own step
  for (genvar r = 0; r < N_RT; r++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q[r] <= '0;
      end else if (step_end && idx_q == IDX_W'(r)) begin
        if (rt_fail_i[r]) res_q[r] <= '{group: FAIL_CODE, mode_id: MODE_RESET};
        else              res_q[r] <= '{group: 8'h00, mode_id: rt_mode_i[r*8 +: 8]};
      end
    end
    assign sts_o[r*STS_W +: STS_W] = (state_q == SEQ_DONE) ? res_q[r] : '0;
  end

  assign busy_o = (state_q == SEQ_RUN);
  assign done_o = (state_q == SEQ_DONE);

  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_busy_done_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  assert_done_after_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: rtl/lic_fec_gate.sv
module lic_fec_gate
  import lic_pkg::*;
#(
  parameter int unsigned N_RT  = 2,
  parameter int unsigned LINKS = 4,
  localparam int unsigned FEC_W = N_RT * LINKS * FEC_BITS
) (
  input  logic                  done_i,
  input  logic [FEC_W-1:0]      fec_req_i,
  input  logic [N_RT*STS_W-1:0] sts_i,
  output logic [FEC_W-1:0]      fec_o
);
  for (genvar r = 0; r < N_RT; r++) begin : g_rt
    sts_t sts;
    logic fec_ok;
    assign sts    = sts_i[r*STS_W +: STS_W];
    // only modes with 25G lanes take a FEC setting
    assign fec_ok = done_i && (sts.group == 8'h00) &&
                    (sts.mode_id != MODE_RESET) && (sts.mode_id != MODE_4X10G);
    for (genvar l = 0; l < LINKS; l++) begin : g_link
      localparam int unsigned LSB = (r * LINKS + l) * FEC_BITS;
      fec_e code;
      assign code = fec_e'(fec_req_i[LSB +: FEC_BITS]);
      assign fec_o[LSB +: FEC_BITS] = (fec_ok && code != FEC_RSVD) ? code : FEC_NONE;
    end
  end
endmodule

// File: rtl/lic_reg_if.sv
module lic_reg_if
  import lic_pkg::*;
#(
  parameter logic [3:0]  VER_MAJOR = 4'd3,
  parameter logic [3:0]  VER_MINOR = 4'd1,
  parameter logic [3:0]  VER_PATCH = 4'd0,
  parameter int unsigned N_RT      = 2,
  parameter int unsigned LINKS     = 4,
  parameter bit          HANDSHAKE = 1'b1,
  localparam int unsigned FEC_W = N_RT * LINKS * FEC_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  input  logic                  busy_i,
  input  logic                  done_i,
  input  logic [N_RT*STS_W-1:0] sts_i,
  output logic                  start_o,
  output logic [FEC_W-1:0]      fec_req_o,
  output logic                  ack_o,
  output logic [31:0]           rdata_o
);
  logic             start_q;
  logic [FEC_W-1:0] fec_q;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;
  logic             ack_q;

  if (HANDSHAKE) begin : g_hs
    assign start_o = req_i && we_i && (addr_i == ADDR_INIT) &&
                     wdata_i[INIT_START_BIT] && !start_q && !done_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_q <= 1'b0;
        fec_q   <= '0;
      end else if (start_o) begin
        start_q <= 1'b1;
        fec_q   <= wdata_i[INIT_FEC_LSB +: FEC_W];
      end
    end

    assert_start_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_q |=> start_q);
    assert_fec_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i || done_i) |=> $stable(fec_q));
  end else begin : g_legacy
    assign start_o = 1'b0;
    assign start_q = 1'b0;
    assign fec_q   = '0;
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_INIT) begin
      rd_mux[INIT_DONE_BIT]              = done_i;
      rd_mux[INIT_START_BIT]             = start_q;
      rd_mux[INIT_FEC_LSB +: FEC_W]      = fec_q;
    end else if (addr_i == ADDR_VER) begin
      rd_mux[31:20] = {VER_MAJOR, VER_MINOR, VER_PATCH};
    end else begin
      for (int r = 0; r < N_RT; r++) begin
        if (addr_i == ADDR_STS_A + ADDR_W'(4 * r)) rd_mux[STS_W-1:0] = sts_i[r*STS_W +: STS_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_i;
      rdata_q <= (req_i && !we_i) ? rd_mux : '0;
    end
  end

  assign ack_o     = ack_q;
  assign rdata_o   = rdata_q;
  assign fec_req_o = fec_q;

  assert_ack_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
endmodule

// File: rtl/link_init_ctrl.sv
module link_init_ctrl
  import lic_pkg::*;
#(
  parameter logic [3:0]  VER_MAJOR   = 4'd3,
  parameter logic [3:0]  VER_MINOR   = 4'd1,
  parameter logic [3:0]  VER_PATCH   = 4'd0,
  parameter int unsigned N_RT        = 2,
  parameter int unsigned LINKS       = 4,
  parameter int unsigned STEP_CYCLES = 32,
  parameter logic [7:0]  FAIL_CODE   = 8'h01
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_req_i,
  input  logic                        reg_we_i,
  input  logic [12:0]                 reg_addr_i,
  input  logic [31:0]                 reg_wdata_i,
  input  logic [N_RT*8-1:0]           rt_mode_i,
  input  logic [N_RT-1:0]             rt_fail_i,
  output logic                        reg_ack_o,
  output logic [31:0]                 reg_rdata_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [N_RT*LINKS*2-1:0]     fec_o
);
  localparam bit          HANDSHAKE = (VER_MAJOR >= 4'd3);
  localparam int unsigned FEC_W     = N_RT * LINKS * FEC_BITS;

  logic                  start;
  logic [FEC_W-1:0]      fec_req;
  logic [N_RT*STS_W-1:0] sts;

  lic_reg_if #(
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH),
    .N_RT(N_RT), .LINKS(LINKS), .HANDSHAKE(HANDSHAKE)
  ) i_reg_if (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_o), .done_i(done_o), .sts_i(sts),
    .start_o(start), .fec_req_o(fec_req),
    .ack_o(reg_ack_o), .rdata_o(reg_rdata_o)
  );

  lic_sequencer #(
    .N_RT(N_RT), .STEP_CYCLES(STEP_CYCLES), .AUTO_START(!HANDSHAKE), .FAIL_CODE(FAIL_CODE)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .rt_mode_i(rt_mode_i), .rt_fail_i(rt_fail_i),
    .busy_o(busy_o), .done_o(done_o), .sts_o(sts)
  );

  lic_fec_gate #(.N_RT(N_RT), .LINKS(LINKS)) i_fec_gate (
    .done_i(done_o), .fec_req_i(fec_req), .sts_i(sts), .fec_o(fec_o)
  );

  assert_fec_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (fec_o == '0));
  assert_sts_hidden_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && !done_o &&
     (reg_addr_i == ADDR_STS_A || reg_addr_i == ADDR_STS_A + 13'd4)) |=> (reg_rdata_o == '0));
  assert_ver_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == ADDR_VER) |=>
      (reg_rdata_o == {VER_MAJOR, VER_MINOR, VER_PATCH, 20'h0}));
endmodule

// File: tb/test_link_init_ctrl.sv
module test_link_init_ctrl;
  localparam int STEP = 8;
  localparam int NRT  = 2;
  localparam int LNK  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] mode = '0;
  logic [1:0]  fail = '0;

  logic        ack, l_ack, busy, l_busy, done, l_done;
  logic [31:0] rdata, l_rdata;
  logic [15:0] fec, l_fec;

  int vectors = 0, miscompares = 0;

  always #10 clk_i = ~clk_i;

  link_init_ctrl #(.VER_MAJOR(4'd3), .VER_MINOR(4'd5), .VER_PATCH(4'd7), .STEP_CYCLES(STEP))
  i_link_init_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .rt_mode_i(mode), .rt_fail_i(fail), .reg_ack_o(ack),
    .reg_rdata_o(rdata), .busy_o(busy), .done_o(done), .fec_o(fec));

  link_init_ctrl #(.VER_MAJOR(4'd2), .STEP_CYCLES(STEP))
  i_link_init_ctrl_legacy (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .rt_mode_i(mode), .rt_fail_i(fail), .reg_ack_o(l_ack),
    .reg_rdata_o(l_rdata), .busy_o(l_busy), .done_o(l_done), .fec_o(l_fec));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  bit          m_start = 0, m_done = 0, m_busy = 0;
  int          m_cnt = 0;
  logic [15:0] m_fec = '0;
  logic        e_ack = 1'b0;
  logic [31:0] e_rd = '0;
  string       e_tag = "R1 rdata";

  function automatic logic [31:0] m_sts(int r);
    if (!m_done) return 32'h0;
    return fail[r] ? 32'h0000_0100 : {24'h0, mode[r*8 +: 8]};
  endfunction

  function automatic logic [31:0] m_read(logic [12:0] a);
    case (a)
      13'h1000: return {8'h0, m_fec, 6'h0, m_start, m_done};
      13'h1004: return {4'd3, 4'd5, 4'd7, 20'h0};
      13'h1020: return m_sts(0);
      13'h1024: return m_sts(1);
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] m_fec_out();
    logic [15:0] f = '0;
    for (int r = 0; r < NRT; r++) begin
      logic [7:0] md = mode[r*8 +: 8];
      for (int l = 0; l < LNK; l++) begin
        logic [1:0] c = m_fec[(r*LNK+l)*2 +: 2];
        if (m_done && !fail[r] && md > 8'd1 && c != 2'd3) f[(r*LNK+l)*2 +: 2] = c;
      end
    end
    return f;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_start = 0; m_done = 0; m_busy = 0; m_cnt = 0; m_fec = '0; e_ack = 0; e_rd = '0;
    end else begin
      e_ack = req;
      e_rd  = (req && !we) ? m_read(addr) : 32'h0;
      case (addr)
        13'h1000: e_tag = "R3 init read";
        13'h1004: e_tag = "R2 version read";
        13'h1020, 13'h1024: e_tag = m_done ? "R7 status read" : "R6 status read";
        default:  e_tag = "R1 rdata";
      endcase
      if (req && we && addr == 13'h1000 && wdata[1] && !m_start && !m_done) begin
        m_start = 1; m_busy = 1; m_cnt = 0; m_fec = wdata[23:8];
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt == NRT * STEP) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R1 ack", {31'h0, ack}, {31'h0, e_ack});
      chk(e_tag, rdata, e_rd);
      chk("R4 done", {31'h0, done}, {31'h0, m_done});
      chk("R10 busy", {31'h0, busy}, {31'h0, m_busy});
      chk("R8 fec", {16'h0, fec}, {16'h0, m_fec_out()});
    end
  end

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk_i); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk_i); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d, output logic [31:0] ld);
    @(negedge clk_i); req = 1; we = 0; addr = a;
    @(negedge clk_i); d = rdata; ld = l_rdata; req = 0;
  endtask

  task automatic restart(logic [15:0] md, logic [1:0] fl);
    @(negedge clk_i); rst_ni = 0; mode = md; fail = fl;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic wait_done();
    while (!m_done) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    logic [31:0] d, ld;
    // run 1: A 4x25G, B 4x10G, no failure
    mode = 16'h0102; fail = 2'b00;
    repeat (3) @(negedge clk_i);
    chk("R10 reset busy", {31'h0, busy}, 32'h0);
    chk("R4 reset done", {31'h0, done}, 32'h0);
    rst_ni = 1;
    for (int k = 1; k <= NRT * STEP; k++) begin
      @(negedge clk_i);
      chk("R9 legacy done timing", {31'h0, l_done}, {31'h0, (k >= NRT * STEP)});
    end
    rd(13'h1004, d, ld);
    chk("R2 version", d, 32'h3570_0000);
    rd(13'h1020, d, ld);
    chk("R6 status A before done", d, 32'h0);
    wr(13'h1000, 32'h00FF_FF00);                // start bit clear
    rd(13'h1000, d, ld);
    chk("R5 write without start ignored", d, 32'h0);
    chk("R9 legacy init read", ld, 32'h1);
    wr(13'h1000, 32'h00AA_C602);
    chk("R4 busy after start", {31'h0, busy}, 32'h1);
    rd(13'h1000, d, ld);
    chk("R3 init during run", d, 32'h00AA_C602);
    wr(13'h1000, 32'h0055_5502);                // second start while running
    rd(13'h1000, d, ld);
    chk("R5 start while running ignored", d, 32'h00AA_C602);
    chk("R9 legacy ignores start", ld, 32'h1);
    chk("R9 legacy fec", {16'h0, l_fec}, 32'h0);
    wait_done();
    rd(13'h1000, d, ld);
    chk("R3 init after done", d, 32'h00AA_C603);
    rd(13'h1020, d, ld);
    chk("R7 status A ok", d, 32'h0000_0002);
    rd(13'h1024, d, ld);
    chk("R7 status B ok", d, 32'h0000_0001);
    chk("R8 fec gated by mode", {16'h0, fec}, 32'h0000_0006);
    wr(13'h1000, 32'h0055_5502);                // start after done
    @(negedge clk_i);
    chk("R5 no restart after done", {30'h0, busy, done}, 32'h1);
    rd(13'h1000, d, ld);
    chk("R5 fields kept after done", d, 32'h00AA_C603);
    rd(13'h1008, d, ld);
    chk("R1 unmapped read", d, 32'h0);

    // run 2: A 1x25G failing, B 2x25G, KR everywhere
    restart(16'h0305, 2'b01);
    wr(13'h1000, 32'h0055_5502);
    wait_done();
    chk("R7 done despite failure", {31'h0, done}, 32'h1);
    rd(13'h1020, d, ld);
    chk("R7 status A failed", d, 32'h0000_0100);
    rd(13'h1024, d, ld);
    chk("R7 status B ok", d, 32'h0000_0003);
    chk("R8 fec failed retimer off", {16'h0, fec}, 32'h0000_5500);

    // run 3: A in reset mode, B 2x25G+2x10G failing, RS everywhere
    restart(16'h0400, 2'b10);
    wr(13'h1000, 32'h00AA_AA02);
    wait_done();
    rd(13'h1020, d, ld);
    chk("R7 status A reset mode", d, 32'h0);
    rd(13'h1024, d, ld);
    chk("R7 status B failed", d, 32'h0000_0100);
    chk("R8 fec all off", {16'h0, fec}, 32'h0);
    repeat (2) @(negedge clk_i);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule